// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock

This block keeps wall-clock time for a chip that must trust its timebase. A free-running sub-second counter advances on every slow, always-on tick. A 32-bit seconds counter advances each time that counter wraps. It only does so once a start-up lifecycle has been completed. The lifecycle has three states. Out of reset the clock sits in an initial state. A control write moves it to a non-valid state, and a second control write moves it to the valid state. The second step is accepted only when a power-glitch key register holds its expected pattern. A later wrong key demotes the clock back to non-valid, and counting stops.

Software reaches the block through a plain register read/write port on the fast bus clock. Every write is carried into the slow domain by a pipeline that advances on slow ticks. The write therefore lands a fixed, small number of slow cycles later. Software can see slow-domain progress by polling the sub-second counter. When the seconds counter reaches a programmed alarm value, an alarm flag is set. The flag drives an interrupt line and a wakeup line, each through its own enable.

Top module: `srtc_ctrl`

## Requirements
- R1: After reset every readable register returns 0, the lifecycle is in the initial state, and irq and wakeup are low.
- R2: A bus write takes effect on the SYNC_STAGES-th slow tick that follows the cycle it was issued in (default 2, so within 3 slow cycles). Until then a read returns the old value. A second write issued before the next slow tick replaces the first.
- R3: The sub-second counter (offset 0x04, LOW_W bits, zero-extended) increments on every slow tick in every lifecycle state and wraps at 2^LOW_W. Writes to it are ignored.
- R4: The seconds counter (offset 0x00) increments on the slow tick where the sub-second counter wraps, and only while the lifecycle is valid. In the other states it holds, but a write still loads it.
- R5: In the initial state, a control write (offset 0x10) with bit 15 and bit 11 both set moves the clock to non-valid and sets status bit 15. A control write lacking either bit leaves the state unchanged.
- R6: In the non-valid state, a control write with bits 15, 14, 11 and 3 all set moves the clock to valid and sets status bit 14. This happens only if the key register (offset 0x18) holds 0x41736166. Otherwise nothing changes.
- R7: In the valid state, a key write of any value other than 0x41736166 returns the clock to non-valid, and the seconds counter stops. The same two-step sequence then makes it valid again.
- R8: The status register (offset 0x14) holds alarm flag bit 3, non-valid-exit-done bit 14 and init-exit-done bit 15. Writing a 1 clears a bit and writing 0 leaves it unchanged.
- R9: The alarm flag is set on the slow tick in which the seconds counter advances to the value held at offset 0x08.
- R10: irq is high exactly while the alarm flag and control bit 7 are both set.
- R11: wakeup is high exactly while the alarm flag and control bit 4 are both set, whatever the value of bit 7.
- R12: A read returns its data on the clock after bus_rd. The control register reads back only bits 3, 4, 7, 11, 14 and 15. Unmapped offsets read 0.
- R13: Between slow ticks the lifecycle state, both counters and the status flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow always-on clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Alarm interrupt |
| wakeup | output | 1 | Alarm wakeup request |

## Verification
The bench runs with a 3-bit sub-second counter, so one second is eight ticks. It derives every expected seconds value from the sub-second reading and the tick count, and it places the alarm at the exact tick where it must fire. The bench then goes after the following corner cases:
- Reads taken one tick after a write. A design that applied writes too early, or never, fails here.
- An exit request missing one control bit, or made with no key programmed. A design that grants validity loosely would start counting.
- A wrong key written while the clock is valid. A design that ignores it would keep counting.
- A pair of back-to-back writes. A design that loses or misorders writes would read back the first value.
- The interrupt enable dropped while the wakeup enable stays set. A design that gated wakeup with bit 7 would drop wakeup.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_SEC = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_SUB = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_ALM = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_CTL = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_STS = 5'h14;
   localparam logic [ADDR_W-1:0] OFS_KEY = 5'h18;

   localparam int C_LPEN = 3;
   localparam int C_WKE  = 4;
   localparam int C_AIE  = 7;
   localparam int C_NSA  = 11;
   localparam int C_NVX  = 14;
   localparam int C_INX  = 15;

   localparam int S_ALM = 3;
   localparam int S_NVD = 14;
   localparam int S_IND = 15;

   localparam logic [DATA_W-1:0] KEY_VAL  = 32'h4173_6166;
   localparam logic [DATA_W-1:0] CTL_MASK = 32'h0000_C898;

   typedef enum logic [1:0] {LC_INIT, LC_NONVALID, LC_VALID} lc_e;

   typedef struct packed {
      logic              vld;
      logic [ADDR_W-1:0] ofs;
      logic [DATA_W-1:0] data;
   } wreq_t;
endpackage

// File: rtl/srtc_wr_sync.sv
module srtc_wr_sync
   import srtc_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  logic [ADDR_W-1:0] ofs,
   input  logic [DATA_W-1:0] wdata,
   output wreq_t             apply
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 1 || STAGES > 2) begin : g_bad_stages
         $error("srtc_wr_sync: STAGES must be 1 or 2");
      end
   endgenerate

   wreq_t pipe_q [STAGES];
   wreq_t head;

   always_comb begin
      head.vld  = 1'b1;
      head.ofs  = ofs;
      head.data = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      end else if (tick) begin
         for (int i = LAST; i > 0; i--) pipe_q[i] <= pipe_q[i-1];
         pipe_q[0] <= we ? head : '0;
      end else if (we) begin
         pipe_q[0] <= head;
      end
   end

   assign apply = (tick && pipe_q[LAST].vld) ? pipe_q[LAST] : '0;
endmodule

// File: rtl/srtc_lifecycle.sv
module srtc_lifecycle
   import srtc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  wreq_t req,
   input  logic  key_ok,
   output lc_e   state,
   output logic  init_done,
   output logic  nv_done
);
   lc_e  state_q, state_d;
   logic ctl_wr, key_wr, init_req, nv_req;

   assign ctl_wr   = req.vld && (req.ofs == OFS_CTL);
   assign key_wr   = req.vld && (req.ofs == OFS_KEY);
   assign init_req = ctl_wr && req.data[C_INX] && req.data[C_NSA];
   assign nv_req   = ctl_wr && req.data[C_INX] && req.data[C_NVX]
                     && req.data[C_NSA] && req.data[C_LPEN] && key_ok;

   always_comb begin
      state_d   = state_q;
      init_done = 1'b0;
      nv_done   = 1'b0;
      case (state_q)
         LC_INIT: if (init_req) begin
            state_d   = LC_NONVALID;
            init_done = 1'b1;
         end
         LC_NONVALID: if (nv_req) begin
            state_d = LC_VALID;
            nv_done = 1'b1;
         end
         LC_VALID: if (key_wr && (req.data != KEY_VAL)) state_d = LC_NONVALID;
         default: state_d = LC_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LC_INIT;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/srtc_timebase.sv
module srtc_timebase
   import srtc_pkg::*;
#(
   parameter int LOW_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              sec_ld,
   input  logic [DATA_W-1:0] sec_val,
   input  logic [DATA_W-1:0] alarm,
   output logic [LOW_W-1:0]  sub,
   output logic [DATA_W-1:0] sec,
   output logic              alarm_hit
);
   generate
      if (LOW_W < 1 || LOW_W > 31) begin : g_bad_low
         $error("srtc_timebase: LOW_W must be 1..31");
      end
   endgenerate

   logic [LOW_W-1:0]  sub_q;
   logic [DATA_W-1:0] sec_q, sec_inc;
   logic              wrap;

   assign wrap    = &sub_q;
   assign sec_inc = sec_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         sec_q <= '0;
      end else if (tick) begin
         sub_q <= sub_q + 1'b1;
         if (sec_ld)           sec_q <= sec_val;
         else if (run && wrap) sec_q <= sec_inc;
      end
   end

   assign alarm_hit = tick && run && wrap && !sec_ld && (sec_inc == alarm);
   assign sub       = sub_q;
   assign sec       = sec_q;
endmodule

// File: rtl/srtc_ctrl.sv
module srtc_ctrl
   import srtc_pkg::*;
#(
   parameter int LOW_W       = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wakeup
);
   localparam int PAD_W = DATA_W - LOW_W;

   wreq_t             req;
   lc_e               lc_q;
   logic              init_done, nv_done, alarm_hit;
   logic              sec_ld, key_ok, sts_wr;
   logic [LOW_W-1:0]  sub_q;
   logic [DATA_W-1:0] sec_q, alarm_q, ctl_q, key_q, rd_mux;
   logic              alm_f, nvd_f, ind_f;

   srtc_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .we(bus_wr),
      .ofs(bus_addr), .wdata(bus_wdata), .apply(req)
   );

   assign key_ok = (key_q == KEY_VAL);

   srtc_lifecycle u_lc (
      .clk(clk), .rst_n(rst_n), .req(req), .key_ok(key_ok),
      .state(lc_q), .init_done(init_done), .nv_done(nv_done)
   );

   assign sec_ld = req.vld && (req.ofs == OFS_SEC);
   assign sts_wr = req.vld && (req.ofs == OFS_STS);

   srtc_timebase #(.LOW_W(LOW_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .run(lc_q == LC_VALID),
      .sec_ld(sec_ld), .sec_val(req.data), .alarm(alarm_q),
      .sub(sub_q), .sec(sec_q), .alarm_hit(alarm_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         ctl_q   <= '0;
         key_q   <= '0;
         alm_f   <= 1'b0;
         nvd_f   <= 1'b0;
         ind_f   <= 1'b0;
      end else begin
         if (req.vld && req.ofs == OFS_ALM) alarm_q <= req.data;
         if (req.vld && req.ofs == OFS_CTL) ctl_q   <= req.data & CTL_MASK;
         if (req.vld && req.ofs == OFS_KEY) key_q   <= req.data;
         alm_f <= (alm_f && !(sts_wr && req.data[S_ALM])) || alarm_hit;
         nvd_f <= (nvd_f && !(sts_wr && req.data[S_NVD])) || nv_done;
         ind_f <= (ind_f && !(sts_wr && req.data[S_IND])) || init_done;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         OFS_SEC: rd_mux = sec_q;
         OFS_SUB: rd_mux = {{PAD_W{1'b0}}, sub_q};
         OFS_ALM: rd_mux = alarm_q;
         OFS_CTL: rd_mux = ctl_q;
         OFS_STS: begin
            rd_mux[S_ALM] = alm_f;
            rd_mux[S_NVD] = nvd_f;
            rd_mux[S_IND] = ind_f;
         end
         OFS_KEY: rd_mux = key_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign irq    = alm_f && ctl_q[C_AIE];
   assign wakeup = alm_f && ctl_q[C_WKE];
endmodule

// File: rtl/srtc_ctrl_chk.sv
module srtc_ctrl_chk
   import srtc_pkg::*;
#(
   parameter int LOW_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slow_tick,
   input lc_e               lc_q,
   input logic [LOW_W-1:0]  sub_q,
   input logic [DATA_W-1:0] sec_q,
   input logic [DATA_W-1:0] key_q,
   input logic              sec_ld,
   input logic              alm_f,
   input logic              nvd_f,
   input logic              ind_f
);
   // R13: nothing in the slow domain moves without a tick
   a_r13_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_tick |=> ($stable(lc_q) && $stable(sub_q) && $stable(sec_q)
                      && $stable(alm_f) && $stable(nvd_f) && $stable(ind_f)));

   // R3: sub-second counter steps by one per tick
   a_r3_sub_steps: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |=> (LOW_W'(sub_q - $past(sub_q)) == LOW_W'(1)));

   // R4: seconds hold outside the valid state unless loaded
   a_r4_hold_unless_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_q != LC_VALID && !sec_ld) |=> $stable(sec_q));

   // R6: entry to valid only with the correct key
   a_r6_valid_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_q == LC_VALID && $past(lc_q) != LC_VALID) |-> (key_q == KEY_VAL));

   // R5: the initial state is never skipped
   a_r5_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_q == LC_VALID) |-> ($past(lc_q) != LC_INIT));

   // R9: the alarm flag only rises on a tick
   a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_f) |-> $past(slow_tick));
endmodule

bind srtc_ctrl srtc_ctrl_chk #(.LOW_W(LOW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .lc_q(lc_q),
   .sub_q(sub_q), .sec_q(sec_q), .key_q(key_q), .sec_ld(sec_ld),
   .alm_f(alm_f), .nvd_f(nvd_f), .ind_f(ind_f)
);

// File: tb/srtc_ctrl_tb.sv
module srtc_ctrl_tb;
   localparam int LOW_W = 3;
   localparam int SPS   = 1 << LOW_W;
   localparam logic [31:0] KEY = 32'h4173_6166;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, wakeup;

   int n_chk = 0;
   int n_fail = 0;
   int ticks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   srtc_ctrl #(.LOW_W(LOW_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .wakeup(wakeup)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); slow_tick = 1'b1;
         @(negedge clk); slow_tick = 1'b0;
         ticks++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      logic [31:0] d, s, l, s1;
      int k;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R12 unmapped offset
      rd(5'h00, d); chk("R1 seconds", d, 0);
      rd(5'h04, d); chk("R1 sub", d, 0);
      rd(5'h08, d); chk("R1 alarm", d, 0);
      rd(5'h10, d); chk("R1 ctrl", d, 0);
      rd(5'h14, d); chk("R1 status", d, 0);
      rd(5'h18, d); chk("R1 key", d, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 wakeup", {31'd0, wakeup}, 0);
      rd(5'h0C, d); chk("R12 unmapped", d, 0);

      // R3 sub-second counter
      tk(3);
      rd(5'h04, d); chk("R3 sub after 3", d, ticks % SPS);

      // R2 write latency
      wr(5'h00, 32'd5);
      tk(1);
      rd(5'h00, d); chk("R2 not yet applied", d, 0);
      tk(1);
      rd(5'h00, d); chk("R2 applied at 2nd tick", d, 5);

      // R4 no counting in init
      tk(20);
      rd(5'h00, d); chk("R4 hold in init", d, 5);
      rd(5'h04, d); chk("R3 sub wrap", d, ticks % SPS);
      wr(5'h04, 32'd7);
      tk(2);
      rd(5'h04, d); chk("R3 write ignored", d, ticks % SPS);

      // R5 init exit
      wr(5'h10, 32'h0000_8000);
      tk(2);
      rd(5'h14, d); chk("R5 missing NSA bit", d, 0);
      wr(5'h10, 32'h0000_8800);
      tk(2);
      rd(5'h14, d); chk("R5 init exit done", d, 32'h0000_8000);

      // R6 non-valid exit
      wr(5'h10, 32'h0000_C808);
      tk(2);
      rd(5'h14, d); chk("R6 no key", d, 32'h0000_8000);
      wr(5'h18, KEY);
      tk(2);
      wr(5'h10, 32'h0000_C800);
      tk(2);
      rd(5'h14, d); chk("R6 missing bit 3", d, 32'h0000_8000);
      wr(5'h10, 32'h0000_C808);
      tk(2);
      rd(5'h14, d); chk("R6 valid reached", d, 32'h0000_C000);
      rd(5'h04, l); rd(5'h00, s);
      tk(10);
      rd(5'h00, d); chk("R4 counting when valid", d, s + (l + 10) / SPS);

      // R8 write-one-to-clear
      wr(5'h14, 32'h0000_4000);
      tk(2);
      rd(5'h14, d); chk("R8 clear bit 14 only", d, 32'h0000_8000);
      wr(5'h14, 32'h0);
      tk(2);
      rd(5'h14, d); chk("R8 zeros no effect", d, 32'h0000_8000);

      // R7 wrong key stops time
      wr(5'h18, 32'h1234_5678);
      tk(2);
      rd(5'h00, s1);
      tk(24);
      rd(5'h00, d); chk("R7 stopped after bad key", d, s1);
      wr(5'h18, KEY);
      tk(2);
      wr(5'h10, 32'h0000_C808);
      tk(2);
      rd(5'h14, d); chk("R7 valid again", d, 32'h0000_C000);

      // R9/R10 alarm with interrupt enable only
      wr(5'h10, 32'h0000_C888);
      tk(2);
      rd(5'h04, l); rd(5'h00, s);
      k = 24 - int'(l);
      wr(5'h08, s + 3);
      tk(k - 1);
      chk("R9 flag not early", {31'd0, irq}, 0);
      tk(1);
      chk("R10 irq on hit", {31'd0, irq}, 1);
      chk("R11 wakeup off", {31'd0, wakeup}, 0);
      rd(5'h14, d); chk("R9 alarm flag", d, 32'h0000_C008);
      rd(5'h00, d); chk("R9 seconds at alarm", d, s + 3);

      // R11 wakeup independent of bit 7
      wr(5'h10, 32'h0000_C898);
      tk(2);
      chk("R11 wakeup on", {31'd0, wakeup}, 1);
      wr(5'h10, 32'h0000_C818);
      tk(2);
      chk("R10 irq off without bit 7", {31'd0, irq}, 0);
      chk("R11 wakeup stays", {31'd0, wakeup}, 1);

      // R8 clear alarm flag
      wr(5'h14, 32'h0000_0008);
      tk(2);
      chk("R8 alarm cleared", {31'd0, wakeup}, 0);
      rd(5'h14, d); chk("R8 status after clear", d, 32'h0000_C000);

      // R2 replacement of an unticked write
      wr(5'h08, 32'hAAAA_0001);
      wr(5'h08, 32'h5555_0002);
      tk(1);
      rd(5'h08, d); chk("R2 alarm old after 1 tick", d, s + 3);
      tk(1);
      rd(5'h08, d); chk("R2 second write wins", d, 32'h5555_0002);

      // R12 control read mask
      wr(5'h10, 32'hFFFF_FFFF);
      tk(2);
      rd(5'h10, d); chk("R12 ctrl mask", d, 32'h0000_C898);

      finish_run();
   end
endmodule